// File: doc/BRIEF.md
# Instruction-Pair Fusion Detector

This block sits in the decode stage of a 64-bit RISC-V style core. Each cycle it receives two adjacent 32-bit instruction words, each with its own valid bit. It decides whether the older instruction (slot 0) and the younger one (slot 1) form one of a fixed catalogue of two-instruction idioms. A matching pair can then be issued as a single internal micro-op. The idioms are shift, logic, add, extend and multiply sequences, and each is keyed to exact shift amounts or immediates.

On a match, the block raises a fuse flag. It also reports a fused-operation code and the merged register operands: the shared destination, the first source of slot 0, and the one second-source register that the pair still needs. It clears the slot 1 valid, because slot 1 has been absorbed. On no match, both words pass through untouched. All outputs are registered and appear one clock after the inputs are sampled. Reset is synchronous.

The block has no state machine. Its only sequential element is the output register stage, which moves between two conditions: in reset, where everything is held at zero, and in normal capture, where one pair is sampled every clock.

Top module: `fuse_detect_top`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge.
- R2: Outputs follow the inputs with one cycle of latency. `slot0_valid_o`, `slot0_insn_o` and `slot1_insn_o` always repeat the previous cycle's inputs. When no fusion occurs, `slot1_valid_o` also repeats the previous cycle's input.
- R3: Fusion requires both `in0_valid` and `in1_valid` to be high.
- R4: Fusion requires four things: slot 1's rd (bits 11:7) equals slot 0's rd; slot 1's rs1 (bits 19:15) equals slot 0's rd; that rd is not x0; and one of the idioms below matches.
- R5: SLLIW by 16 then SRLIW by 16 gives code 1. SLLIW by 16 then SRAIW by 16 gives code 2. Any other word-shift amount does not fuse.
- R6: SLLI by 1, 2 or 3 then ADD gives code 3. SLLI by 4 then ADD gives code 4. Other left-shift amounts do not fuse.
- R7: SLLI by 32 then SRLI by 29, 30 or 31 gives code 5. Other right-shift amounts do not fuse.
- R8: SRLI by 8 then ANDI 255 gives code 6. SRLI by 29, 30, 31 or 32 then ADD gives code 7. ANDI with any immediate other than 255 after SRLI by 8 does not fuse.
- R9: ANDI 1 then ADD or ADDW gives code 8. ADDW then ANDI 1, ANDI 255, ZEXT.H or SEXT.H gives code 9.
- R10: Let the first instruction be any of AND, OR, XOR, ANDI, ORI, XORI or ORC.B. Followed by ANDI 1, the pair gives code 10. Followed by ZEXT.H, it gives code 11.
- R11: ANDI -256 then OR gives code 12. ANDI 127 then MULW gives code 13.
- R12: When fused, `slot1_valid_o` is low and `fuse_rd_o`/`fuse_rs1_o` carry slot 0's rd/rs1. `fuse_rs2_o` carries slot 1's rs2 if slot 1 is a register-register op; otherwise slot 0's rs2 if slot 0 is; otherwise 0. When not fused, the code and all three operand outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in0_valid | input | 1 | Older instruction present |
| in0_insn | input | 32 | Older instruction word |
| in1_valid | input | 1 | Younger instruction present |
| in1_insn | input | 32 | Younger instruction word |
| fuse_o | output | 1 | Pair fused |
| fuse_kind_o | output | 4 | Fused-operation code (0 = none) |
| fuse_rd_o | output | 5 | Shared destination register |
| fuse_rs1_o | output | 5 | First source of the fused op |
| fuse_rs2_o | output | 5 | Second source of the fused op |
| slot0_valid_o | output | 1 | Registered slot 0 valid |
| slot0_insn_o | output | 32 | Registered slot 0 word |
| slot1_valid_o | output | 1 | Registered slot 1 valid, cleared when fused |
| slot1_insn_o | output | 32 | Registered slot 1 word |

## Verification
The hardest cases to reach are the near misses. In these, the opcodes form a legal idiom but one detail breaks it: an immediate one step off, a destination of x0, a register chain that does not link, or a dropped valid bit. Random words almost never hit these, so the stimulus builds each pair from field-level encoders. For every idiom it then perturbs exactly one field, so that the same opcode pair is seen both fusing and refusing. A scoreboard holds the expected code and operands per pair and compares them one cycle later.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    localparam int ILEN   = 32;
    localparam int REG_W  = 5;
    localparam int IMM_W  = 12;
    localparam int SHW    = 6;
    localparam int KIND_W = 4;
    localparam int SLOTS  = 2;

    localparam logic [6:0] OPC_IMM   = 7'b0010011;
    localparam logic [6:0] OPC_IMM32 = 7'b0011011;
    localparam logic [6:0] OPC_REG   = 7'b0110011;
    localparam logic [6:0] OPC_REG32 = 7'b0111011;

    localparam logic [IMM_W-1:0] IMM_ORCB  = 12'h287;
    localparam logic [IMM_W-1:0] IMM_SEXTH = 12'h605;

    typedef enum logic [KIND_W-1:0] {
        K_NONE      = 4'd0,
        K_ZEXT16    = 4'd1,
        K_SEXT16    = 4'd2,
        K_SHL_ADD   = 4'd3,
        K_SHL4_ADD  = 4'd4,
        K_ZEXTW_SHL = 4'd5,
        K_BYTE1     = 4'd6,
        K_SHR_ADD   = 4'd7,
        K_ADD_ODD   = 4'd8,
        K_ADDW_EXT  = 4'd9,
        K_LOGIC_LSB = 4'd10,
        K_LOGIC_LO16= 4'd11,
        K_CLR_OR    = 4'd12,
        K_MUL7      = 4'd13
    } kind_e;

    typedef struct packed {
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rs1;
        logic [REG_W-1:0] rs2;
        logic [SHW-1:0]   shamt;
        logic [IMM_W-1:0] imm;
        logic             slliw;
        logic             srliw;
        logic             sraiw;
        logic             slli;
        logic             srli;
        logic             add;
        logic             addw;
        logic             andi;
        logic             ori;
        logic             xori;
        logic             andr;
        logic             orr;
        logic             xorr;
        logic             orcb;
        logic             zexth;
        logic             sexth;
        logic             mulw;
        logic             uses_rs2;
    } dec_t;

endpackage

// File: rtl/fuse_insn_decode.sv
module fuse_insn_decode
    import fuse_pkg::*;
(
    input  logic [ILEN-1:0] insn,
    output dec_t            dec
);

    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;
    logic [5:0] f6;
    logic       is_imm, is_imm32, is_reg, is_reg32;

    always_comb begin
        opc      = insn[6:0];
        f3       = insn[14:12];
        f7       = insn[31:25];
        f6       = insn[31:26];
        is_imm   = (opc == OPC_IMM);
        is_imm32 = (opc == OPC_IMM32);
        is_reg   = (opc == OPC_REG);
        is_reg32 = (opc == OPC_REG32);

        dec       = '0;
        dec.rd    = insn[11:7];
        dec.rs1   = insn[19:15];
        dec.rs2   = insn[24:20];
        dec.shamt = insn[25:20];
        dec.imm   = insn[31:20];

        // immediate forms
        dec.slli  = is_imm && (f3 == 3'd1) && (f6 == 6'd0);
        dec.srli  = is_imm && (f3 == 3'd5) && (f6 == 6'd0);
        dec.andi  = is_imm && (f3 == 3'd7);
        dec.ori   = is_imm && (f3 == 3'd6);
        dec.xori  = is_imm && (f3 == 3'd4);
        dec.orcb  = is_imm && (f3 == 3'd5) && (insn[31:20] == IMM_ORCB);
        dec.sexth = is_imm && (f3 == 3'd1) && (insn[31:20] == IMM_SEXTH);

        // word immediate shifts
        dec.slliw = is_imm32 && (f3 == 3'd1) && (f7 == 7'h00);
        dec.srliw = is_imm32 && (f3 == 3'd5) && (f7 == 7'h00);
        dec.sraiw = is_imm32 && (f3 == 3'd5) && (f7 == 7'h20);

        // register-register forms
        dec.add   = is_reg && (f3 == 3'd0) && (f7 == 7'h00);
        dec.andr  = is_reg && (f3 == 3'd7) && (f7 == 7'h00);
        dec.orr   = is_reg && (f3 == 3'd6) && (f7 == 7'h00);
        dec.xorr  = is_reg && (f3 == 3'd4) && (f7 == 7'h00);
        dec.addw  = is_reg32 && (f3 == 3'd0) && (f7 == 7'h00);
        dec.mulw  = is_reg32 && (f3 == 3'd0) && (f7 == 7'h01);
        dec.zexth = is_reg32 && (f3 == 3'd4) && (f7 == 7'h04)
                    && (insn[24:20] == 5'd0);

        dec.uses_rs2 = (is_reg || is_reg32) && !dec.zexth;
    end

endmodule

// File: rtl/fuse_pair_match.sv
module fuse_pair_match
    import fuse_pkg::*;
(
    input  dec_t             a,
    input  dec_t             b,
    input  logic             va,
    input  logic             vb,
    output logic             hit,
    output kind_e            kind,
    output logic [REG_W-1:0] rs2_sel
);

    kind_e cand;
    logic  chain_ok;
    logic  logic_first;

    always_comb begin
        chain_ok    = (b.rd == a.rd) && (b.rs1 == a.rd) && (a.rd != '0);
        logic_first = a.andr | a.orr | a.xorr | a.andi | a.ori | a.xori | a.orcb;

        if (a.slliw && a.shamt == 6'd16 && b.srliw && b.shamt == 6'd16)
            cand = K_ZEXT16;
        else if (a.slliw && a.shamt == 6'd16 && b.sraiw && b.shamt == 6'd16)
            cand = K_SEXT16;
        else if (a.slli && a.shamt >= 6'd1 && a.shamt <= 6'd3 && b.add)
            cand = K_SHL_ADD;
        else if (a.slli && a.shamt == 6'd4 && b.add)
            cand = K_SHL4_ADD;
        else if (a.slli && a.shamt == 6'd32 && b.srli
                 && b.shamt >= 6'd29 && b.shamt <= 6'd31)
            cand = K_ZEXTW_SHL;
        else if (a.srli && a.shamt == 6'd8 && b.andi && b.imm == 12'd255)
            cand = K_BYTE1;
        else if (a.srli && a.shamt >= 6'd29 && a.shamt <= 6'd32 && b.add)
            cand = K_SHR_ADD;
        else if (a.andi && a.imm == 12'd1 && (b.add || b.addw))
            cand = K_ADD_ODD;
        else if (a.addw && ((b.andi && (b.imm == 12'd1 || b.imm == 12'd255))
                            || b.zexth || b.sexth))
            cand = K_ADDW_EXT;
        else if (logic_first && b.andi && b.imm == 12'd1)
            cand = K_LOGIC_LSB;
        else if (logic_first && b.zexth)
            cand = K_LOGIC_LO16;
        else if (a.andi && a.imm == 12'hF00 && b.orr)
            cand = K_CLR_OR;
        else if (a.andi && a.imm == 12'd127 && b.mulw)
            cand = K_MUL7;
        else
            cand = K_NONE;

        hit  = va && vb && chain_ok && (cand != K_NONE);
        kind = hit ? cand : K_NONE;

        if (b.uses_rs2)      rs2_sel = b.rs2;
        else if (a.uses_rs2) rs2_sel = a.rs2;
        else                 rs2_sel = '0;
    end

endmodule

// File: rtl/fuse_detect_top.sv
module fuse_detect_top
    import fuse_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in0_valid,
    input  logic [31:0]       in0_insn,
    input  logic              in1_valid,
    input  logic [31:0]       in1_insn,
    output logic              fuse_o,
    output logic [3:0]        fuse_kind_o,
    output logic [4:0]        fuse_rd_o,
    output logic [4:0]        fuse_rs1_o,
    output logic [4:0]        fuse_rs2_o,
    output logic              slot0_valid_o,
    output logic [31:0]       slot0_insn_o,
    output logic              slot1_valid_o,
    output logic [31:0]       slot1_insn_o
);

    logic [ILEN-1:0] slot_insn [SLOTS];
    dec_t            slot_dec  [SLOTS];

    assign slot_insn[0] = in0_insn;
    assign slot_insn[1] = in1_insn;

    for (genvar s = 0; s < SLOTS; s++) begin : g_dec
        fuse_insn_decode u_dec (
            .insn (slot_insn[s]),
            .dec  (slot_dec[s])
        );
    end

    logic             m_hit;
    kind_e            m_kind;
    logic [REG_W-1:0] m_rs2;

    fuse_pair_match u_match (
        .a       (slot_dec[0]),
        .b       (slot_dec[1]),
        .va      (in0_valid),
        .vb      (in1_valid),
        .hit     (m_hit),
        .kind    (m_kind),
        .rs2_sel (m_rs2)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fuse_o        <= 1'b0;
            fuse_kind_o   <= '0;
            fuse_rd_o     <= '0;
            fuse_rs1_o    <= '0;
            fuse_rs2_o    <= '0;
            slot0_valid_o <= 1'b0;
            slot0_insn_o  <= '0;
            slot1_valid_o <= 1'b0;
            slot1_insn_o  <= '0;
        end else begin
            fuse_o        <= m_hit;
            fuse_kind_o   <= m_kind;
            fuse_rd_o     <= m_hit ? slot_dec[0].rd  : '0;
            fuse_rs1_o    <= m_hit ? slot_dec[0].rs1 : '0;
            fuse_rs2_o    <= m_hit ? m_rs2           : '0;
            slot0_valid_o <= in0_valid;
            slot0_insn_o  <= in0_insn;
            slot1_valid_o <= in1_valid && !m_hit;
            slot1_insn_o  <= in1_insn;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (!fuse_o && fuse_kind_o == 4'd0 && !slot0_valid_o && !slot1_valid_o)); // R1
    AST_PASS_SLOT0: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (slot0_valid_o == $past(in0_valid) && slot0_insn_o == $past(in0_insn))); // R2
    AST_NEED_BOTH_VALID: assert property (@(posedge clk) disable iff (rst)
        fuse_o |-> $past(in0_valid && in1_valid)); // R3
    AST_CHAIN_LINK: assert property (@(posedge clk) disable iff (rst)
        fuse_o |-> ($past(in1_insn[19:15]) == $past(in0_insn[11:7])
                    && $past(in1_insn[11:7]) == $past(in0_insn[11:7]))); // R4
    AST_NO_X0_DEST: assert property (@(posedge clk) disable iff (rst)
        fuse_o |-> (fuse_rd_o != 5'd0)); // R4
    AST_SLOT1_ABSORBED: assert property (@(posedge clk) disable iff (rst)
        fuse_o |-> !slot1_valid_o); // R12
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !fuse_o |-> (fuse_kind_o == 4'd0 && fuse_rd_o == 5'd0 && fuse_rs2_o == 5'd0)); // R12

endmodule

// File: tb/tb_fuse_detect_top.sv
module tb_fuse_detect_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in0_valid = 1'b0, in1_valid = 1'b0;
    logic [31:0] in0_insn = '0, in1_insn = '0;
    logic        fuse_o, slot0_valid_o, slot1_valid_o;
    logic [3:0]  fuse_kind_o;
    logic [4:0]  fuse_rd_o, fuse_rs1_o, fuse_rs2_o;
    logic [31:0] slot0_insn_o, slot1_insn_o;

    always #10 clk = ~clk;

    fuse_detect_top dut (
        .clk(clk), .rst(rst),
        .in0_valid(in0_valid), .in0_insn(in0_insn),
        .in1_valid(in1_valid), .in1_insn(in1_insn),
        .fuse_o(fuse_o), .fuse_kind_o(fuse_kind_o),
        .fuse_rd_o(fuse_rd_o), .fuse_rs1_o(fuse_rs1_o), .fuse_rs2_o(fuse_rs2_o),
        .slot0_valid_o(slot0_valid_o), .slot0_insn_o(slot0_insn_o),
        .slot1_valid_o(slot1_valid_o), .slot1_insn_o(slot1_insn_o)
    );

    typedef struct {
        int          due;
        logic [85:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [85:0] outvec();
        return {fuse_o, fuse_kind_o, fuse_rd_o, fuse_rs1_o, fuse_rs2_o,
                slot0_valid_o, slot0_insn_o, slot1_valid_o, slot1_insn_o};
    endfunction

    // encoders
    localparam logic [6:0] OI = 7'b0010011, OW = 7'b0011011, OR_ = 7'b0110011, OR32 = 7'b0111011;
    function automatic logic [31:0] ityp(input logic [11:0] imm, input logic [4:0] rs1,
                                         input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] opc);
        return {imm, rs1, f3, rd, opc};
    endfunction
    function automatic logic [31:0] rtyp(input logic [6:0] f7, input logic [4:0] rs2, input logic [4:0] rs1,
                                         input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] opc);
        return {f7, rs2, rs1, f3, rd, opc};
    endfunction
    // first instruction: rd 5, rs1 6, rs2 8 ; second: rd 5, rs1 5, rs2 7
    function automatic logic [31:0] slli_(input int sh);  return ityp(12'(sh), 5'd6, 3'd1, 5'd5, OI); endfunction
    function automatic logic [31:0] srli_(input int sh, input logic [4:0] rs1); return ityp(12'(sh), rs1, 3'd5, 5'd5, OI); endfunction
    function automatic logic [31:0] slliw_(input int sh); return ityp(12'(sh), 5'd6, 3'd1, 5'd5, OW); endfunction
    function automatic logic [31:0] srliw_(input int sh); return ityp(12'(sh), 5'd5, 3'd5, 5'd5, OW); endfunction
    function automatic logic [31:0] sraiw_(input int sh); return ityp({7'h20, 5'(sh)}, 5'd5, 3'd5, 5'd5, OW); endfunction
    function automatic logic [31:0] andi_(input logic [11:0] imm, input logic [4:0] rs1); return ityp(imm, rs1, 3'd7, 5'd5, OI); endfunction
    function automatic logic [31:0] add2(input logic [4:0] rd, input logic [4:0] rs1); return rtyp(7'h00, 5'd7, rs1, 3'd0, rd, OR_); endfunction
    function automatic logic [31:0] addw2(); return rtyp(7'h00, 5'd7, 5'd5, 3'd0, 5'd5, OR32); endfunction
    function automatic logic [31:0] addw1(); return rtyp(7'h00, 5'd8, 5'd6, 3'd0, 5'd5, OR32); endfunction
    function automatic logic [31:0] zexth2(); return rtyp(7'h04, 5'd0, 5'd5, 3'd4, 5'd5, OR32); endfunction
    function automatic logic [31:0] sexth2(); return ityp(12'h605, 5'd5, 3'd1, 5'd5, OI); endfunction

    task automatic pair(input logic [31:0] a, input logic [31:0] b, input logic va, input logic vb,
                        input logic [3:0] k, input logic [4:0] r2, input string tag);
        item_t it;
        logic f;
        @(negedge clk);
        in0_insn = a; in1_insn = b; in0_valid = va; in1_valid = vb;
        f = (k != 4'd0);
        it.due = cyc + 1;
        it.tag = tag;
        it.exp = {f, k, f ? a[11:7] : 5'd0, f ? a[19:15] : 5'd0, f ? r2 : 5'd0,
                  va, a, vb && !f, b};
        q.push_back(it);
    endtask

    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (outvec() !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, outvec(), it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        in0_valid = 1'b1; in1_valid = 1'b1;
        in0_insn = slliw_(16); in1_insn = srliw_(16);
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (outvec() !== 86'd0) begin
            errors++;
            $display("FAIL R1 actual=%h expected=%h", outvec(), 86'd0);
        end
        rst = 1'b0;

        // R5 halfword idioms
        pair(slliw_(16), srliw_(16), 1, 1, 4'd1, 5'd0, "R5 zext16");
        pair(slliw_(16), sraiw_(16), 1, 1, 4'd2, 5'd0, "R5 sext16");
        pair(slliw_(15), srliw_(16), 1, 1, 4'd0, 5'd0, "R5 wrong shift");
        // R6 shift-left-add
        for (int s = 1; s <= 3; s++)
            pair(slli_(s), add2(5'd5, 5'd5), 1, 1, 4'd3, 5'd7, "R6 shl123 add");
        pair(slli_(4), add2(5'd5, 5'd5), 1, 1, 4'd4, 5'd7, "R6 shl4 add");
        pair(slli_(5), add2(5'd5, 5'd5), 1, 1, 4'd0, 5'd0, "R6 shl5 no fuse");
        // R7 zero-extended word shift
        for (int s = 29; s <= 31; s++)
            pair(slli_(32), srli_(s, 5'd5), 1, 1, 4'd5, 5'd0, "R7 zextw shl");
        pair(slli_(32), srli_(28, 5'd5), 1, 1, 4'd0, 5'd0, "R7 srli28 no fuse");
        // R8
        pair(ityp(12'd8, 5'd6, 3'd5, 5'd5, OI), andi_(12'd255, 5'd5), 1, 1, 4'd6, 5'd0, "R8 byte1");
        pair(ityp(12'd8, 5'd6, 3'd5, 5'd5, OI), andi_(12'd254, 5'd5), 1, 1, 4'd0, 5'd0, "R8 mask254");
        for (int s = 29; s <= 32; s++)
            pair(ityp(12'(s), 5'd6, 3'd5, 5'd5, OI), add2(5'd5, 5'd5), 1, 1, 4'd7, 5'd7, "R8 shr add");
        // R9
        pair(andi_(12'd1, 5'd6), add2(5'd5, 5'd5), 1, 1, 4'd8, 5'd7, "R9 odd add");
        pair(andi_(12'd1, 5'd6), addw2(), 1, 1, 4'd8, 5'd7, "R9 odd addw");
        pair(addw1(), andi_(12'd1, 5'd5), 1, 1, 4'd9, 5'd8, "R9 addw andi1");
        pair(addw1(), andi_(12'd255, 5'd5), 1, 1, 4'd9, 5'd8, "R9 addw andi255");
        pair(addw1(), zexth2(), 1, 1, 4'd9, 5'd8, "R9 addw zexth");
        pair(addw1(), sexth2(), 1, 1, 4'd9, 5'd8, "R9 addw sexth");
        // R10
        pair(rtyp(7'h00, 5'd8, 5'd6, 3'd7, 5'd5, OR_), andi_(12'd1, 5'd5), 1, 1, 4'd10, 5'd8, "R10 and lsb");
        pair(rtyp(7'h00, 5'd8, 5'd6, 3'd6, 5'd5, OR_), andi_(12'd1, 5'd5), 1, 1, 4'd10, 5'd8, "R10 or lsb");
        pair(rtyp(7'h00, 5'd8, 5'd6, 3'd4, 5'd5, OR_), andi_(12'd1, 5'd5), 1, 1, 4'd10, 5'd8, "R10 xor lsb");
        pair(andi_(12'd3, 5'd6), andi_(12'd1, 5'd5), 1, 1, 4'd10, 5'd0, "R10 andi lsb");
        pair(ityp(12'd9, 5'd6, 3'd6, 5'd5, OI), andi_(12'd1, 5'd5), 1, 1, 4'd10, 5'd0, "R10 ori lsb");
        pair(ityp(12'd9, 5'd6, 3'd4, 5'd5, OI), andi_(12'd1, 5'd5), 1, 1, 4'd10, 5'd0, "R10 xori lsb");
        pair(ityp(12'h287, 5'd6, 3'd5, 5'd5, OI), andi_(12'd1, 5'd5), 1, 1, 4'd10, 5'd0, "R10 orcb lsb");
        pair(rtyp(7'h00, 5'd8, 5'd6, 3'd4, 5'd5, OR_), zexth2(), 1, 1, 4'd11, 5'd8, "R10 xor lo16");
        pair(ityp(12'd9, 5'd6, 3'd6, 5'd5, OI), zexth2(), 1, 1, 4'd11, 5'd0, "R10 ori lo16");
        // R11
        pair(andi_(12'hF00, 5'd6), rtyp(7'h00, 5'd7, 5'd5, 3'd6, 5'd5, OR_), 1, 1, 4'd12, 5'd7, "R11 clear or");
        pair(andi_(12'd127, 5'd6), rtyp(7'h01, 5'd7, 5'd5, 3'd0, 5'd5, OR32), 1, 1, 4'd13, 5'd7, "R11 mul7");
        pair(andi_(12'd126, 5'd6), rtyp(7'h01, 5'd7, 5'd5, 3'd0, 5'd5, OR32), 1, 1, 4'd0, 5'd0, "R11 mask126");
        // R4 dependency rule
        pair(slli_(2), add2(5'd9, 5'd5), 1, 1, 4'd0, 5'd0, "R4 rd mismatch");
        pair(slli_(2), add2(5'd5, 5'd6), 1, 1, 4'd0, 5'd0, "R4 rs1 unlinked");
        pair(ityp(12'd2, 5'd6, 3'd1, 5'd0, OI), add2(5'd0, 5'd0), 1, 1, 4'd0, 5'd0, "R4 x0 dest");
        // R3 valids, R2 pass-through, R12 operand outputs
        pair(slliw_(16), srliw_(16), 1, 0, 4'd0, 5'd0, "R3 slot1 invalid");
        pair(slliw_(16), srliw_(16), 0, 1, 4'd0, 5'd0, "R3 slot0 invalid");
        pair(32'h0000_0013, 32'h0040_0093, 1, 1, 4'd0, 5'd0, "R2 plain pass");
        pair(slli_(1), add2(5'd5, 5'd5), 1, 1, 4'd3, 5'd7, "R12 fused operands");
        pair(32'h0, 32'h0, 0, 0, 4'd0, 5'd0, "R2 idle");

        repeat (4) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R2 actual=%0d expected=0 pending results", q.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule